// File: doc/BRIEF.md
# Real-Mode Physical Address Former with Bit-20 Gate

This block turns a 16-bit segment value and a 16-bit offset into a physical address. The address is the segment multiplied by sixteen plus the offset. The sum can exceed 1 MiB by up to 65,520 bytes, so it is carried as a 21-bit value and then zero-extended onto a 32-bit physical address bus.

Bit 20 of the sum can be removed, which wraps the address back to the bottom of the first megabyte. Three things remove it:
- an active-low gate pin, which passes through a two-flop synchronizer first;
- a per-request legacy input that imitates a core with 20-bit addresses;
- a build-time parameter that fixes the block into the 20-bit behaviour for good.

A request is presented with a valid strobe. The address and its valid flag come out registered, one cycle later.

Top module: `rm_addr_former`

## Requirements
- R1: With no clearing source active, `physAddr` equals `{segIn, 4'b0000} + offIn`, computed to 21 bits without truncation.
- R2: With `gateMaskN` high and `legacyMode` low, bit 20 is kept. Segment 0xFFFF with offset 0xFFFF gives 0x0010FFEF, and segment 0xF800 with offset 0x8000 gives 0x00100000.
- R3: When `legacyMode` is high at the capturing edge, bit 20 of the result is zero. Segment 0xFFFF with offset 0xFFFF then gives 0x0000FFEF.
- R4: When the synchronized `gateMaskN` is low (asserted), bit 20 of the result is zero, so the address wraps at 1 MiB.
- R5: A level change on `gateMaskN` affects requests captured two or more rising edges after the edge that first samples the new level. Requests captured on that first edge, or on the edge after it, still use the previous level.
- R6: Bits 31 down to 21 of `physAddr` are always zero.
- R7: `physValid` is high in exactly the cycle after a cycle in which `reqValid` was sampled high. The new address appears in that same cycle.
- R8: A cycle without `reqValid` leaves `physAddr` unchanged and drives `physValid` low.
- R9: During reset, `physAddr` is 0 and `physValid` is 0. The synchronizer resets to the not-asserted level (high).
- R10: With parameter `LEGACY_ONLY` set to 1, bit 20 is zero for every request, whatever `gateMaskN` and `legacyMode` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe for segment and offset |
| segIn | input | 16 | Segment value |
| offIn | input | 16 | Offset within the segment |
| gateMaskN | input | 1 | Asynchronous gate pin. Low clears address bit 20 |
| legacyMode | input | 1 | High selects 20-bit truncation for this request |
| physAddr | output | 32 | Registered physical address |
| physValid | output | 1 | High in the cycle that `physAddr` carries a new result |

## Verification
The hardest situation to reach is the window while the gate pin is still moving through the synchronizer. In that window a request must still see the old gate level, even though the pin already shows the new one. The stimulus lowers the pin in the same cycle that it starts a run of back-to-back requests at 0xFFFF:0xFFFF. The first two results must then keep bit 20, and the third must have it cleared. The other vector tests wait three cycles after every pin change, so the synchronizer has settled before each request.

// File: rtl/rm_addr_pkg.sv
package rm_addr_pkg;
  localparam int SEG_W   = 16;
  localparam int OFF_W   = 16;
  localparam int SHIFT_W = 4;
  localparam int PA_W    = 32;
  localparam int BASE_W  = SEG_W + SHIFT_W;
  localparam int SUM_W   = ((BASE_W > OFF_W) ? BASE_W : OFF_W) + 1;
  localparam int WRAP_BIT = SUM_W - 1;

  typedef struct packed {
    logic load;
    logic clearTop;
  } ctrl_strobe_t;
endpackage

// File: rtl/rm_addr_ctrl.sv
module rm_addr_ctrl
  import rm_addr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit LEGACY_ONLY = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         gateMaskN,
  input  logic         legacyMode,
  output ctrl_strobe_t strobes,
  output logic         validQ
);
  logic [SYNC_STAGES-1:0] syncChain;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[0] <= 1'b1;
          else       syncChain[0] <= gateMaskN;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[s] <= 1'b1;
          else       syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  logic maskActive;
  logic modeClear;
  assign maskActive = ~syncChain[SYNC_STAGES-1];

  generate
    if (LEGACY_ONLY) begin : g_fixed_legacy
      assign modeClear = 1'b1;
    end else begin : g_sel_legacy
      assign modeClear = legacyMode;
    end
  endgenerate

  always_comb begin
    strobes.load     = reqValid;
    strobes.clearTop = maskActive | modeClear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= reqValid;
  end

  // R7: valid follows a sampled request by one cycle
  p_valid_after_req_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> validQ);
  // R8: no request, no valid
  p_idle_no_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !validQ);
endmodule

// File: rtl/rm_addr_dp.sv
module rm_addr_dp
  import rm_addr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strobe_t     strobes,
  input  logic [SEG_W-1:0] segIn,
  input  logic [OFF_W-1:0] offIn,
  output logic [SUM_W-1:0] addrQ
);
  logic [SUM_W-1:0] baseExt;
  logic [SUM_W-1:0] offExt;
  logic [SUM_W-1:0] rawSum;
  logic [SUM_W-1:0] gatedSum;

  always_comb begin
    baseExt  = SUM_W'({segIn, {SHIFT_W{1'b0}}});
    offExt   = SUM_W'(offIn);
    rawSum   = baseExt + offExt;
    gatedSum = rawSum;
    if (strobes.clearTop) gatedSum[WRAP_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             addrQ <= '0;
    else if (strobes.load) addrQ <= gatedSum;
  end

  // R3, R4: a clearing capture never leaves bit 20 set
  p_wrap_cleared_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.clearTop) |=> !addrQ[WRAP_BIT]);
  // R8: the register holds without a load
  p_hold_no_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(addrQ));
endmodule

// File: rtl/rm_addr_former.sv
module rm_addr_former
  import rm_addr_pkg::*;
#(
  parameter bit LEGACY_ONLY = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [15:0] segIn,
  input  logic [15:0] offIn,
  input  logic        gateMaskN,
  input  logic        legacyMode,
  output logic [31:0] physAddr,
  output logic        physValid
);
  ctrl_strobe_t     strobes;
  logic [SUM_W-1:0] addrQ;

  rm_addr_ctrl #(.SYNC_STAGES(2), .LEGACY_ONLY(LEGACY_ONLY)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .gateMaskN(gateMaskN),
    .legacyMode(legacyMode), .strobes(strobes), .validQ(physValid)
  );

  rm_addr_dp dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .segIn(segIn),
    .offIn(offIn), .addrQ(addrQ)
  );

  assign physAddr = PA_W'(addrQ);

  // R6: upper bus bits stay zero
  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    physAddr[PA_W-1:SUM_W] == '0);
  // R3: legacy request yields a result without bit 20
  p_legacy_trunc_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && legacyMode) |=> !physAddr[WRAP_BIT]);
  // R10: fixed legacy build never sets bit 20
  p_fixed_legacy_r10: assert property (@(posedge clk) disable iff (!rstN)
    (LEGACY_ONLY && physValid) |-> !physAddr[WRAP_BIT]);
endmodule

// File: tb/rm_addr_former_tb.sv
module rm_addr_former_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 8;
  // {seg, off, maskN, legacy, expected}
  localparam logic [16+16+1+1+32-1:0] VEC [NVEC] = '{
    {16'h1234, 16'h0010, 1'b1, 1'b0, 32'h0001_2350},
    {16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 32'h0010_FFEF},
    {16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 32'h0000_FFEF},
    {16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 32'h0000_FFEF},
    {16'hF800, 16'h8000, 1'b1, 1'b0, 32'h0010_0000},
    {16'hF800, 16'h8000, 1'b0, 1'b0, 32'h0000_0000},
    {16'h0000, 16'h0000, 1'b1, 1'b0, 32'h0000_0000},
    {16'hA000, 16'hFFFF, 1'b1, 1'b0, 32'h000A_FFFF}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [15:0] segIn = '0, offIn = '0;
  logic gateMaskN = 1'b1, legacyMode = 1'b0;
  logic [31:0] physAddr, legPhysAddr;
  logic physValid, legPhysValid;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rm_addr_former dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .segIn(segIn), .offIn(offIn),
    .gateMaskN(gateMaskN), .legacyMode(legacyMode),
    .physAddr(physAddr), .physValid(physValid)
  );

  rm_addr_former #(.LEGACY_ONLY(1'b1)) dutLegacy_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .segIn(segIn), .offIn(offIn),
    .gateMaskN(gateMaskN), .legacyMode(legacyMode),
    .physAddr(legPhysAddr), .physValid(legPhysValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R9: reset state
    repeat (2) @(negedge clk);
    check("R9 addr", physAddr, 32'h0);
    check("R9 valid", {31'b0, physValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      gateMaskN  = VEC[i][33];
      legacyMode = VEC[i][32];
      repeat (3) @(negedge clk);
      segIn = VEC[i][65:50];
      offIn = VEC[i][49:34];
      reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      // R1 R2 R3 R4 R6 address; R7 valid
      check($sformatf("R1 vec%0d", i), physAddr, VEC[i][31:0]);
      check($sformatf("R7 vec%0d", i), {31'b0, physValid}, 32'h1);
      check($sformatf("R10 vec%0d", i), legPhysAddr, VEC[i][31:0] & 32'h000F_FFFF);
    end

    // R8: idle cycles hold the address and drop valid
    @(negedge clk);
    check("R8 valid", {31'b0, physValid}, 32'h0);
    check("R8 hold", physAddr, 32'h000A_FFFF);
    segIn = 16'h0001;
    offIn = 16'h0001;
    @(negedge clk);
    check("R8 hold after input change", physAddr, 32'h000A_FFFF);

    // R5: pin lowered together with back-to-back requests
    gateMaskN = 1'b1;
    legacyMode = 1'b0;
    repeat (3) @(negedge clk);
    segIn = 16'hFFFF;
    offIn = 16'hFFFF;
    gateMaskN = 1'b0;
    reqValid = 1'b1;
    @(negedge clk);
    check("R5 first edge old level", physAddr, 32'h0010_FFEF);
    @(negedge clk);
    check("R5 second edge old level", physAddr, 32'h0010_FFEF);
    @(negedge clk);
    check("R5 third edge new level", physAddr, 32'h0000_FFEF);
    reqValid = 1'b0;
    @(negedge clk);
    check("R7 valid drops", {31'b0, physValid}, 32'h0);

    // R5: release the pin the same way
    gateMaskN = 1'b1;
    reqValid = 1'b1;
    @(negedge clk);
    check("R5 release first edge", physAddr, 32'h0000_FFEF);
    @(negedge clk);
    check("R5 release second edge", physAddr, 32'h0000_FFEF);
    @(negedge clk);
    check("R2 release third edge", physAddr, 32'h0010_FFEF);
    check("R10 fixed legacy ignores pin", legPhysAddr, 32'h0000_FFEF);
    reqValid = 1'b0;

    // R9: reset in mid-run clears outputs
    rstN = 1'b0;
    @(negedge clk);
    check("R9 re-reset addr", physAddr, 32'h0);
    check("R9 re-reset valid", {31'b0, physValid}, 32'h0);
    finish_run();
  end
endmodule